// File: doc/BRIEF.md
# RMII Receive Elasticity Buffer

This block moves received dibits from the clock recovered off the line into the local 50 MHz RMII reference domain. Across one packet, the two clocks can drift apart by a few bits. A small buffer between the two domains absorbs that drift. At the start of each packet the buffer is allowed to fill to a margin before anything is played out, so a slower writer has slack before the reader catches up.

The margin is set by a 2-bit tolerance selector. The encoding is not monotonic:

| `tol_sel` | Margin (bits) | Margin (dibits) |
|---|---|---|
| 01 | 2 | 1 |
| 10 | 6 | 3 |
| 11 | 10 | 5 |
| 00 | 14 | 7 |

- The writer adds an end-of-packet marker after the last dibit. The reader uses it to drain, drop its valid output and return to pre-fill.
- A write that finds the buffer full records an overflow and cuts the packet short.
- A reader that finds the buffer empty in mid-packet records an underflow and discards the rest of that packet.
- Both conditions are held in sticky status flags until a clear strobe is applied.

Top module: `rmii_rx_elastic`

## Requirements
- R1: After a packet starts, `rd_dv` stays low until the buffer holds at least the selected margin: 7, 1, 3 or 5 dibits for `tol_sel` 00, 01, 10 or 11. The first valid dibit appears no later than one further write-clock period after that margin is reached.
- R2: When the write and read clocks run at the same rate, every dibit of a packet comes out on `rd_dibit` in arrival order. The packet appears as exactly one unbroken burst of `rd_dv`.
- R3: While reset is asserted, `rd_dv`, `rd_dibit`, `ovf_flag` and `unf_flag` are all 0.
- R4: After the last dibit of a packet, `rd_dv` falls and `rd_dibit` returns to 00. The next packet pre-fills again and is delivered intact.
- R5: If the buffer runs empty before the end-of-packet marker is read, `unf_flag` is set and `rd_dv` falls at once. The rest of that packet is discarded, so the delivered dibits are a prefix of the packet.
- R6: A write that finds the buffer full sets `ovf_flag`. Every later dibit of that packet is dropped, and the packet is closed with a marker. The delivered dibits are a strict prefix of the sent packet.
- R7: `ovf_flag` and `unf_flag` stay at 1 until `clr` is sampled high. When a new event and `clr` coincide, the event wins and the flag reads 1.
- R8: Each pointer changes in at most one bit per clock of its own domain when it crosses to the other domain, so data delivered across an arbitrary clock phase is intact.
- R9: The fill level seen from either side never exceeds DEPTH entries and never wraps, so no stored dibit is overwritten before it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write domain) |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_dv | input | 1 | Receive data valid, write domain |
| wr_dibit | input | 2 | Receive dibit, write domain |
| rd_clk | input | 1 | 50 MHz RMII reference clock (read domain) |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| tol_sel | input | 2 | Tolerance selector: 00=14, 01=2, 10=6, 11=10 bits |
| clr | input | 1 | Clears both status flags, read domain |
| rd_dv | output | 1 | Carrier/data valid toward the MAC |
| rd_dibit | output | 2 | Dibit toward the MAC, 00 when not valid |
| ovf_flag | output | 1 | Sticky overflow status |
| unf_flag | output | 1 | Sticky underflow status |

## Verification
A flag can be set by an underflow or overflow event in the same read-clock cycle as a clear strobe. The bench holds `clr` high for a whole packet that is forced to underflow by a writer eight times slower than the reader. It then requires two things: the flag was seen at 1 on at least one cycle while `clr` was high, and the flag is 0 once the event has passed. A matching packet with `clr` low must leave the flag set long afterwards.

// File: rtl/rmii_eb_pkg.sv
package rmii_eb_pkg;

   // One buffer slot: either a data dibit or an end-of-packet marker.
   typedef struct packed {
      logic       eop;
      logic [1:0] dibit;
   } eb_entry_t;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_STREAM = 2'd1,
      RD_FLUSH  = 2'd2
   } eb_rd_state_t;

   // Largest margin the selector can ask for, in dibits (14 bits).
   localparam int unsigned MAX_MARGIN_DIBITS = 7;

   // Margin in bits: 00 selects 14; 01/10/11 select 2/6/10, i.e. 4*sel-2.
   function automatic logic [2:0] margin_dibits(input logic [1:0] sel);
      logic [4:0] bits;
      if (sel == 2'b00) bits = 5'd14;
      else              bits = 5'({sel, 2'b00}) - 5'd2;
      return bits[3:1];
   endfunction

endpackage

// File: rtl/eb_sync_vec.sv
module eb_sync_vec #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("eb_sync_vec: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/eb_store.sv
module eb_store
   import rmii_eb_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic      wr_clk,
   input  logic      we,
   input  logic [AW-1:0] waddr,
   input  eb_entry_t wentry,
   input  logic [AW-1:0] raddr,
   output eb_entry_t rentry
);

   eb_entry_t mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wentry;
   end

   assign rentry = mem[raddr];

endmodule

// File: rtl/eb_wr_ctrl.sv
module eb_wr_ctrl
   import rmii_eb_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          wr_clk,
   input  logic          wr_rst_n,
   input  logic          wr_dv,
   input  logic [1:0]    wr_dibit,
   input  logic [PW-1:0] rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output eb_entry_t     wentry,
   output logic [PW-1:0] wgray,
   output logic          ovf_tgl
);

   logic [PW-1:0] wbin, wbin_nxt, rbin_s, used;
   logic          dv_q, drop, mark_pend;
   logic          full, fall, need_mark, ovf_hit;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   assign rbin_s    = g2b(rgray_s);
   assign used      = wbin - rbin_s;
   assign full      = (used == PW'(DEPTH));
   assign fall      = dv_q & ~wr_dv;
   assign need_mark = mark_pend | (fall & ~drop);
   assign ovf_hit   = wr_dv & ~drop & ~need_mark & full;
   assign waddr     = wbin[AW-1:0];
   assign wbin_nxt  = wbin + PW'(we);

   always_comb begin
      we     = 1'b0;
      wentry = '{eop: 1'b0, dibit: wr_dibit};
      if (need_mark) begin
         we     = ~full;
         wentry = '{eop: 1'b1, dibit: 2'b00};
      end else if (wr_dv && !drop && !full) begin
         we = 1'b1;
      end
   end

   always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
         wbin      <= '0;
         wgray     <= '0;
         dv_q      <= 1'b0;
         drop      <= 1'b0;
         mark_pend <= 1'b0;
         ovf_tgl   <= 1'b0;
      end else begin
         wbin      <= wbin_nxt;
         wgray     <= wbin_nxt ^ (wbin_nxt >> 1);
         dv_q      <= wr_dv;
         mark_pend <= need_mark ? full : ovf_hit;
         drop      <= wr_dv ? (drop | ovf_hit) : 1'b0;
         if (ovf_hit) ovf_tgl <= ~ovf_tgl;
      end
   end

   AST_WR_FILL_BOUND: assert property (@(posedge wr_clk) disable iff (!wr_rst_n) used <= PW'(DEPTH)); // R9
   AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n) $countones(wgray ^ $past(wgray)) <= 1); // R8

endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
   import rmii_eb_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic          rd_clk,
   input  logic          rd_rst_n,
   input  logic [PW-1:0] wgray_s,
   input  logic [1:0]    tol_sel,
   input  eb_entry_t     rentry,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic          rd_dv,
   output logic [1:0]    rd_dibit,
   output logic          unf_evt
);

   eb_rd_state_t  state, nstate;
   logic [PW-1:0] rbin, rbin_nxt, wbin_s, fill;
   logic [2:0]    margin;
   logic          empty, rd_en, dv_nxt;

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   assign wbin_s   = g2b(wgray_s);
   assign fill     = wbin_s - rbin;
   assign empty    = (fill == '0);
   assign margin   = margin_dibits(tol_sel);
   assign raddr    = rbin[AW-1:0];
   assign rbin_nxt = rbin + PW'(rd_en);

   always_comb begin
      nstate  = state;
      rd_en   = 1'b0;
      unf_evt = 1'b0;
      unique case (state)
         RD_IDLE: begin
            if (fill >= PW'(margin)) nstate = RD_STREAM;
         end
         RD_STREAM: begin
            if (empty) begin
               unf_evt = 1'b1;
               nstate  = RD_FLUSH;
            end else begin
               rd_en = 1'b1;
               if (rentry.eop) nstate = RD_IDLE;
            end
         end
         RD_FLUSH: begin
            if (!empty) begin
               rd_en = 1'b1;
               if (rentry.eop) nstate = RD_IDLE;
            end
         end
         default: nstate = RD_IDLE;
      endcase
   end

   assign dv_nxt = (state == RD_STREAM) & rd_en & ~rentry.eop;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         state    <= RD_IDLE;
         rbin     <= '0;
         rgray    <= '0;
         rd_dv    <= 1'b0;
         rd_dibit <= 2'b00;
      end else begin
         state    <= nstate;
         rbin     <= rbin_nxt;
         rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
         rd_dv    <= dv_nxt;
         rd_dibit <= dv_nxt ? rentry.dibit : 2'b00;
      end
   end

   AST_RD_FILL_BOUND: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) fill <= PW'(DEPTH)); // R9
   AST_PREFILL_MARGIN: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) $rose(rd_dv) |-> $past(fill) >= PW'(margin)); // R1
   AST_UNF_DROPS_DV: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) unf_evt |=> !rd_dv); // R5
   AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) $countones(rgray ^ $past(rgray)) <= 1); // R8

endmodule

// File: rtl/eb_status.sv
module eb_status (
   input  logic rd_clk,
   input  logic rd_rst_n,
   input  logic ovf_tgl_s,
   input  logic unf_evt,
   input  logic clr,
   output logic ovf_flag,
   output logic unf_flag
);

   logic tgl_q, ovf_evt;

   assign ovf_evt = ovf_tgl_s ^ tgl_q;

   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n) begin
         tgl_q    <= 1'b0;
         ovf_flag <= 1'b0;
         unf_flag <= 1'b0;
      end else begin
         tgl_q <= ovf_tgl_s;
         // an event in the same cycle as clr takes precedence
         if (ovf_evt)  ovf_flag <= 1'b1;
         else if (clr) ovf_flag <= 1'b0;
         if (unf_evt)  unf_flag <= 1'b1;
         else if (clr) unf_flag <= 1'b0;
      end
   end

   AST_OVF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) (ovf_flag && !clr) |=> ovf_flag); // R7
   AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) (unf_flag && !clr) |=> unf_flag); // R7
   AST_UNF_SET_WINS: assert property (@(posedge rd_clk) disable iff (!rd_rst_n) unf_evt |=> unf_flag); // R7

endmodule

// File: rtl/rmii_rx_elastic.sv
module rmii_rx_elastic
   import rmii_eb_pkg::*;
#(
   parameter  int DEPTH       = 16,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic       wr_clk,
   input  logic       wr_rst_n,
   input  logic       wr_dv,
   input  logic [1:0] wr_dibit,
   input  logic       rd_clk,
   input  logic       rd_rst_n,
   input  logic [1:0] tol_sel,
   input  logic       clr,
   output logic       rd_dv,
   output logic [1:0] rd_dibit,
   output logic       ovf_flag,
   output logic       unf_flag
);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth_pow2
         $error("rmii_rx_elastic: DEPTH must be a power of two");
      end
      if (DEPTH < 2 * MAX_MARGIN_DIBITS) begin : g_bad_depth_size
         $error("rmii_rx_elastic: DEPTH must hold twice the largest margin");
      end
   endgenerate

   logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
   logic [AW-1:0] waddr, raddr;
   eb_entry_t     wentry, rentry;
   logic          we, ovf_tgl, ovf_tgl_s, unf_evt;

   eb_sync_vec #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .din(wgray), .dout(wgray_s));

   eb_sync_vec #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .din(rgray), .dout(rgray_s));

   eb_sync_vec #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ovf (
      .clk(rd_clk), .rst_n(rd_rst_n), .din(ovf_tgl), .dout(ovf_tgl_s));

   eb_store #(.DEPTH(DEPTH)) u_store (
      .wr_clk(wr_clk), .we(we), .waddr(waddr), .wentry(wentry),
      .raddr(raddr), .rentry(rentry));

   eb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_dv(wr_dv), .wr_dibit(wr_dibit),
      .rgray_s(rgray_s), .we(we), .waddr(waddr), .wentry(wentry),
      .wgray(wgray), .ovf_tgl(ovf_tgl));

   eb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .wgray_s(wgray_s), .tol_sel(tol_sel),
      .rentry(rentry), .raddr(raddr), .rgray(rgray), .rd_dv(rd_dv),
      .rd_dibit(rd_dibit), .unf_evt(unf_evt));

   eb_status u_status (
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .ovf_tgl_s(ovf_tgl_s),
      .unf_evt(unf_evt), .clr(clr), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

endmodule

// File: tb/rmii_rx_elastic_tb.sv
`timescale 1ns/1ps
module rmii_rx_elastic_tb;

   localparam real RD_PERIOD       = 20.0;
   localparam int  WATCHDOG_CYCLES = 150000;
   localparam int  SEED            = 1234;

   logic       wr_clk = 1'b0, rd_clk = 1'b0;
   logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic       wr_dv = 1'b0, clr = 1'b0;
   logic [1:0] wr_dibit = 2'b00, tol_sel = 2'b01;
   logic       rd_dv, ovf_flag, unf_flag;
   logic [1:0] rd_dibit;

   real wr_half = 10.0;

   int  n_chk = 0, n_bad = 0;
   logic [1:0] sent [128];
   logic [1:0] got  [128];
   int  ngot = 0, bursts = 0, rise_cnt = 0, wr_count = 0;
   bit  rise_seen = 1'b0, prev_dv = 1'b0, saw_clr_flag = 1'b0;

   rmii_rx_elastic u_dut (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_dv(wr_dv), .wr_dibit(wr_dibit),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .tol_sel(tol_sel), .clr(clr),
      .rd_dv(rd_dv), .rd_dibit(rd_dibit), .ovf_flag(ovf_flag), .unf_flag(unf_flag));

   always #(RD_PERIOD / 2.0) rd_clk = ~rd_clk;

   initial begin
      #7.0;
      forever #(wr_half) wr_clk = ~wr_clk;
   end

   // Margin in dibits for each selector code, from the requirements.
   function automatic int margin_of(input logic [1:0] s);
      case (s)
         2'b00:   return 7;
         2'b01:   return 1;
         2'b10:   return 3;
         default: return 5;
      endcase
   endfunction

   function automatic int mismatches();
      int m = 0;
      for (int i = 0; i < ngot; i++) if (got[i] != sent[i]) m++;
      return m;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Read-side monitor, sampled away from the active edge.
   always @(negedge rd_clk) begin
      if (rd_rst_n) begin
         if (rd_dv) begin
            if (!prev_dv) begin
               bursts++;
               if (!rise_seen) begin
                  rise_cnt  = wr_count;
                  rise_seen = 1'b1;
               end
            end
            if (ngot < 128) begin
               got[ngot] = rd_dibit;
               ngot++;
            end
         end
         prev_dv = rd_dv;
         if (clr && unf_flag) saw_clr_flag = 1'b1;
      end
   end

   task automatic send(input int len);
      for (int i = 0; i < len; i++) sent[i] = 2'($urandom);
      ngot = 0; bursts = 0; rise_seen = 1'b0; wr_count = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge wr_clk);
         wr_dv    = 1'b1;
         wr_dibit = sent[i];
         wr_count++;
      end
      @(negedge wr_clk);
      wr_dv    = 1'b0;
      wr_dibit = 2'b00;
      repeat (80) @(negedge rd_clk);
   endtask

   task automatic set_tol(input logic [1:0] t);
      @(negedge rd_clk);
      tol_sel = t;
   endtask

   task automatic pulse_clr();
      @(negedge rd_clk); clr = 1'b1;
      @(negedge rd_clk); clr = 1'b0;
      repeat (3) @(negedge rd_clk);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge rd_clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(SEED));
      repeat (5) @(negedge rd_clk);
      // R3: reset values
      chk(rd_dv == 1'b0,     "R3 rd_dv in reset", int'(rd_dv), 0);
      chk(rd_dibit == 2'b00, "R3 rd_dibit in reset", int'(rd_dibit), 0);
      chk(ovf_flag == 1'b0,  "R3 ovf_flag in reset", int'(ovf_flag), 0);
      chk(unf_flag == 1'b0,  "R3 unf_flag in reset", int'(unf_flag), 0);
      @(negedge rd_clk) rd_rst_n = 1'b1;
      @(negedge wr_clk) wr_rst_n = 1'b1;
      repeat (5) @(negedge rd_clk);

      // Random packets at equal rates, random margin and length.
      for (int k = 0; k < 16; k++) begin
         int len;
         set_tol(2'($urandom));
         len = 8 + int'($urandom % 40);
         send(len);
         chk(mismatches() == 0, "R2 R8 dibit order", mismatches(), 0);
         chk(ngot == len,       "R2 dibit count", ngot, len);
         chk(bursts == 1,       "R4 one burst per packet", bursts, 1);
         chk(!ovf_flag && !unf_flag, "R2 no status at equal rates",
             int'({ovf_flag, unf_flag}), 0);
      end

      // Slow writer: measure the pre-fill point, then underflow.
      wr_half = 80.0;
      for (int t = 0; t < 4; t++) begin
         int m;
         set_tol(2'(t));
         m = margin_of(2'(t));
         send(12);
         chk(rise_seen && rise_cnt >= m && rise_cnt <= m + 1, "R1 prefill margin", rise_cnt, m);
         chk(unf_flag == 1'b1,   "R5 underflow flag", int'(unf_flag), 1);
         chk(mismatches() == 0,  "R5 delivered prefix", mismatches(), 0);
         chk(rd_dv == 1'b0 && rd_dibit == 2'b00, "R4 dv low after packet",
             int'({rd_dv, rd_dibit}), 0);
         pulse_clr();
         chk(unf_flag == 1'b0,   "R7 clear of underflow", int'(unf_flag), 0);
      end

      // Event and clear in the same cycle: event must win.
      @(negedge rd_clk) clr = 1'b1;
      saw_clr_flag = 1'b0;
      send(12);
      chk(saw_clr_flag == 1'b1, "R7 set wins over clr", int'(saw_clr_flag), 1);
      chk(unf_flag == 1'b0,     "R7 clr held clears", int'(unf_flag), 0);
      @(negedge rd_clk) clr = 1'b0;

      // Sticky with no clear.
      send(12);
      repeat (200) @(negedge rd_clk);
      chk(unf_flag == 1'b1, "R7 underflow sticky", int'(unf_flag), 1);
      pulse_clr();

      // Fast writer, long packet: overflow.
      wr_half = 5.0;
      set_tol(2'b00);
      send(60);
      chk(ovf_flag == 1'b1,  "R6 overflow flag", int'(ovf_flag), 1);
      chk(unf_flag == 1'b0,  "R6 no underflow on truncation", int'(unf_flag), 0);
      chk(mismatches() == 0, "R9 no overwrite, prefix intact", mismatches(), 0);
      chk(ngot < 60 && ngot >= 7, "R6 packet truncated", ngot, 59);
      chk(bursts == 1,       "R4 truncated packet one burst", bursts, 1);
      repeat (200) @(negedge rd_clk);
      chk(ovf_flag == 1'b1,  "R7 overflow sticky", int'(ovf_flag), 1);
      pulse_clr();
      chk(ovf_flag == 1'b0,  "R7 clear of overflow", int'(ovf_flag), 0);

      // Recovery at equal rates after the error cases.
      wr_half = 10.0;
      set_tol(2'b00);
      send(30);
      chk(mismatches() == 0, "R4 recovery data", mismatches(), 0);
      chk(ngot == 30,        "R4 recovery count", ngot, 30);
      chk(!ovf_flag && !unf_flag, "R4 recovery status", int'({ovf_flag, unf_flag}), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule